// File: doc/BRIEF.md
# Microsecond Reload Timer with Interrupt Status

This block is a free-running system timer for a byte-wide peripheral bus. A prescaler divides the core clock (by four by default, giving a tick near one microsecond from a 3.6864 MHz clock) and each tick advances an up-counter. When the counter steps past all-ones it does not fall to zero. It reloads from a software-written reload latch and raises a timeout flag, so the latch sets the interval between timeouts.

A small status register collects the timeout flag and a second flag set by a once-per-second pulse from an external real-time clock. A pending bit, also driven on `irq_o`, is the OR of the two flags. Software clears a flag by writing zero to its bit. Reading the counter low byte snapshots the high byte, so that two byte reads give a coherent 16-bit value.

Register select on `addr_i`: 0 is status (read: bit 0 one-second flag, bit 1 timeout flag, bit 7 pending, others 0; write: a 0 in bit 0 or bit 1 clears that flag). 1 reads the counter low byte and writes the latch low byte. 2 reads the snapshot high byte and writes the latch high byte. 3 reads 0 and ignores writes.

Top module: `usec_timer`

## Requirements
- R1: After reset the counter starts at 0 and increments by one once every DIV clock cycles, the first increment on the DIV-th rising edge after reset release.
- R2: A tick taken while the counter is all-ones loads the reload latch value into the counter instead of 0.
- R3: The same tick that reloads the counter sets status bit 1, the timeout flag.
- R4: Writes to address 1 and address 2 set the latch low and high bytes. A latch write does not change the running count. Writes to address 3 change nothing, and reads of address 3 return 0.
- R5: A read of address 1 returns the counter low byte and captures the counter high bits into a snapshot register. Address 2 returns that snapshot, zero-extended to 8 bits.
- R6: A high level on `sec_irq_i` at a rising edge sets status bit 0.
- R7: Status bit 7 and `irq_o` are 1 exactly when bit 0 or bit 1 is set. Status bits 2 to 6 read 0.
- R8: A status write with a 0 in bit 0 or bit 1 clears that flag, and a 1 leaves it unchanged. A set event in the same cycle as a clear leaves the flag set.
- R9: Reset clears the counter, prescaler, latch, snapshot and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe, used for the snapshot capture |
| rdata_o | output | 8 | Read data for the selected register, combinational |
| sec_irq_i | input | 1 | One-second event from the real-time clock |
| irq_o | output | 1 | Interrupt pending |

## Verification
The bench builds the timer with a 10-bit counter and a divide of 3. This brings the first rollover within about three thousand cycles, so every run reaches several reloads. The bench sweeps ten reload values, including 0, the all-ones value (which reloads on every tick) and values in between. At each sample it predicts the count, the wrap count and the snapshot arithmetically from the number of edges elapsed, and checks them just before and just after the first rollover. Directed runs then cover the reset state, the ignored address, flag clears, and the same-cycle set/clear collision for both flags.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_LO     = 2'd1,
    SEL_HI     = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int unsigned STAT_RTC  = 0;
  localparam int unsigned STAT_TMO  = 1;
  localparam int unsigned STAT_PEND = 7;
  localparam int unsigned BYTE_W    = 8;
endpackage

// File: rtl/usec_prescale.sv
module usec_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] div_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             div_q <= '0;
        else if (div_q == LAST)  div_q <= '0;
        else                     div_q <= div_q + 1'b1;
      end

      assign tick_o = (div_q == LAST);

      // R1: ticks are isolated when dividing
      assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/usec_reload_counter.sv
module usec_reload_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = tick_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wrap_o)  cnt_q <= reload_i;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !(&cnt_o)) |=> (cnt_o == $past(cnt_o) + 1'b1));
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
  assert_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_o == $past(reload_i)));
endmodule

// File: rtl/usec_irq_status.sv
module usec_irq_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_rtc_i,
  input  logic set_tmo_i,
  input  logic wr_i,
  input  logic keep_rtc_i,
  input  logic keep_tmo_i,
  output logic rtc_o,
  output logic tmo_o,
  output logic pend_o
);
  logic rtc_q, tmo_q;
  logic clr_rtc, clr_tmo;

  assign clr_rtc = wr_i && !keep_rtc_i;
  assign clr_tmo = wr_i && !keep_tmo_i;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rtc_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      rtc_q <= set_rtc_i | (rtc_q & ~clr_rtc);
      tmo_q <= set_tmo_i | (tmo_q & ~clr_tmo);
    end
  end

  assign rtc_o  = rtc_q;
  assign tmo_o  = tmo_q;
  assign pend_o = rtc_q | tmo_q;

  assert_rtc_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_rtc_i |=> rtc_o);
  assert_tmo_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_tmo_i |=> tmo_o);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_tmo && !set_tmo_i) |=> !tmo_o);
endmodule

// File: rtl/usec_timer.sv
module usec_timer
  import usec_timer_pkg::*;
#(
  parameter int unsigned TIMER_W = 16,
  parameter int unsigned DIV     = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  input  logic       rd_en_i,
  output logic [7:0] rdata_o,
  input  logic       sec_irq_i,
  output logic       irq_o
);
  localparam int unsigned HI_W = TIMER_W - BYTE_W;

  reg_sel_e           sel;
  logic               tick, wrap;
  logic [TIMER_W-1:0] cnt, latch_q;
  logic [HI_W-1:0]    snap_q;
  logic               rtc, tmo, pend;
  logic [7:0]         status_byte, snap_byte;

  assign sel = reg_sel_e'(addr_i);

  usec_prescale #(.DIV(DIV)) i_prescale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  usec_reload_counter #(.W(TIMER_W)) i_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .reload_i (latch_q),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  usec_irq_status i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_rtc_i  (sec_irq_i),
    .set_tmo_i  (wrap),
    .wr_i       (wr_en_i && sel == SEL_STATUS),
    .keep_rtc_i (wdata_i[STAT_RTC]),
    .keep_tmo_i (wdata_i[STAT_TMO]),
    .rtc_o      (rtc),
    .tmo_o      (tmo),
    .pend_o     (pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
    end else if (wr_en_i) begin
      if (sel == SEL_LO) latch_q[BYTE_W-1:0]       <= wdata_i;
      if (sel == SEL_HI) latch_q[TIMER_W-1:BYTE_W] <= wdata_i[HI_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       snap_q <= '0;
    else if (rd_en_i && sel == SEL_LO) snap_q <= cnt[TIMER_W-1:BYTE_W];
  end

  always_comb begin
    status_byte            = '0;
    status_byte[STAT_RTC]  = rtc;
    status_byte[STAT_TMO]  = tmo;
    status_byte[STAT_PEND] = pend;
    snap_byte              = '0;
    snap_byte[HI_W-1:0]    = snap_q;
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS: rdata_o = status_byte;
      SEL_LO:     rdata_o = cnt[BYTE_W-1:0];
      SEL_HI:     rdata_o = snap_byte;
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = pend;

  assert_snapshot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd1) |=> (snap_q == $past(cnt[TIMER_W-1:BYTE_W])));
  assert_latch_steady_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || addr_i == 2'd0 || addr_i == 2'd3) |=> $stable(latch_q));
  assert_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (rdata_o[STAT_PEND] || sel != SEL_STATUS ? irq_o : 1'b0));
endmodule

// File: tb/test_usec_timer.sv
`timescale 1ns/1ps
module test_usec_timer;
  localparam int TW   = 10;
  localparam int PD   = 3;
  localparam int MAXV = (1 << TW) - 1;
  localparam int W0   = PD * (MAXV + 1);

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0, sec_irq = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;
  int         edge_n;
  int         n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) edge_n <= 0;
    else         edge_n <= edge_n + 1;

  usec_timer #(.TIMER_W(TW), .DIV(PD)) i_usec_timer (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata),
    .sec_irq_i(sec_irq), .irq_o(irq)
  );

  function automatic int exp_val(int n, int l);
    int t = n / PD;
    if (t <= MAXV) return t;
    t -= MAXV + 1;
    return l + t % (MAXV + 1 - l);
  endfunction

  function automatic int exp_wraps(int n, int l);
    int t = n / PD;
    if (t <= MAXV) return 0;
    return 1 + (t - MAXV - 1) / (MAXV + 1 - l);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at edge %0d", req, act, expv, edge_n);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; wr_en = 1'b0; rd_en = 1'b0; sec_irq = 1'b0;
    addr = 2'd0; wdata = 8'd0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic go_to(int n);
    while (edge_n < n) @(negedge clk);
  endtask

  task automatic sample(int l);
    int v, w;
    addr = 2'd0; rd_en = 1'b0; #1;
    w = exp_wraps(edge_n, l) > 0;
    chk("R3 R7 status", rdata, w ? 8'h82 : 8'h00);
    chk("R7 irq_o", irq, w);
    @(negedge clk);
    addr = 2'd1; rd_en = 1'b1; #1;
    v = exp_val(edge_n, l);
    chk("R1 R2 low byte", rdata, v & 255);
    @(negedge clk);
    addr = 2'd2; rd_en = 1'b0; #1;
    chk("R5 snapshot high", rdata, v >> 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int lat[10] = '{0, 1, 341, 512, 682, 768, 960, 1008, 1022, 1023};
    int per;

    // R9: reset state
    do_reset();
    #1;
    chk("R9 status after reset", rdata, 0);
    chk("R9 irq after reset", irq, 0);
    addr = 2'd2; #1;
    chk("R9 snapshot after reset", rdata, 0);
    addr = 2'd1; #1;
    chk("R9 count after reset", rdata, 0);
    // R9 latch reset to 0; R4 address 3 ignored
    @(negedge clk);
    bus_wr(2'd3, 8'hFF);
    addr = 2'd3; #1;
    chk("R4 address 3 reads zero", rdata, 0);
    go_to(W0 + 3 + PD * 5);
    sample(0);

    // R1 R2 R3 R4 R5: reload sweep
    for (int i = 0; i < 10; i++) begin
      per = MAXV + 1 - lat[i];
      do_reset();
      bus_wr(2'd1, 8'(lat[i] & 255));
      bus_wr(2'd2, 8'(lat[i] >> 8));
      go_to(301);                       sample(lat[i]);
      go_to(W0 - 2);                    sample(lat[i]);
      go_to(W0 + 3);                    sample(lat[i]);
      go_to(W0 + 3 + PD * per + 5);     sample(lat[i]);
      go_to(W0 + 3 + 2 * PD * per + 11); sample(lat[i]);
    end

    // R6 R8: one-second flag
    do_reset();
    go_to(10);
    sec_irq = 1'b1;
    @(negedge clk);
    sec_irq = 1'b0; addr = 2'd0; #1;
    chk("R6 one-second flag", rdata, 8'h81);
    chk("R7 irq with flag", irq, 1);
    @(negedge clk);
    bus_wr(2'd0, 8'h03); #1;
    chk("R8 write 1 keeps flag", rdata, 8'h81);
    @(negedge clk);
    bus_wr(2'd0, 8'h02); #1;
    chk("R8 write 0 clears flag", rdata, 8'h00);
    chk("R7 irq cleared", irq, 0);
    @(negedge clk);
    sec_irq = 1'b1;
    bus_wr(2'd0, 8'h00);
    sec_irq = 1'b0; #1;
    chk("R8 set wins over clear rtc", rdata, 8'h81);

    // R3 R8: timeout flag collision with latch all-ones
    do_reset();
    bus_wr(2'd1, 8'hFF);
    bus_wr(2'd2, 8'h03);
    go_to(W0 + 6);
    while (edge_n % PD != PD - 1) @(negedge clk);
    bus_wr(2'd0, 8'h00); #1;
    chk("R8 set wins over clear tmo", rdata, 8'h82);
    @(negedge clk);
    while (edge_n % PD != 0) @(negedge clk);
    bus_wr(2'd0, 8'h01); #1;
    chk("R8 timeout cleared", rdata, 8'h00);
    chk("R7 irq after clear", irq, 0);
    while (edge_n % PD != 1) @(negedge clk);
    @(negedge clk); @(negedge clk); @(negedge clk); #1;
    chk("R3 timeout set again", rdata, 8'h82);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule